// File: doc/BRIEF.md
# PCM Timeslot Serial Port

This block moves 16-bit voice samples between parallel words and a framed serial highway. It is clocked by the highway bit clock `pclk`. A frame sync input `fsync` marks the start of each frame. A frame counter counts bit-clock cycles from that mark. The transmit path and the receive path each compare that count against a start value of their own, and the match places the 16-bit word in the frame. Transmit bits leave most significant bit first and change on the rising edge. Receive bits are sampled on the falling edge, and the assembled word is presented with a one-cycle valid strobe.

The serial transmit output is split into a data bit and an output enable, so that the pad ring can build a three-state driver. The enable is high only while a word is on the line. A mode bit selects where the enable drops:
- halfway through the final bit cell, which avoids contention with a driver that takes the next slot;
- or at the rising edge that ends the final bit cell.

Two further modes are available:
- Wideband mode places a second word half a frame after the first, in both directions.
- Double-clock mode stretches every bit over two bit-clock cycles.

The frame length in bit-clock cycles is an input. The counter stops at that length until the next frame sync. A start value at or beyond the frame length therefore turns that direction off.

Top module: `pcm_port`

## Requirements
- R1: A high `fsync` at a rising edge makes the frame count 0 in the following cycle. The count then rises by one per cycle and stops at `frameLen` until the next `fsync`. Out of reset the count is parked, so that no transfer happens before the first `fsync`; `rxWord` resets to 0.
- R2: The transmit word is sent most significant bit first. Its first bit is on `dtxData` in the cycle whose count equals `txStart`, and one bit follows per cycle. `dtxOe` is high for exactly those 16 cycles.
- R3: `drx` is sampled on the falling edge in the 16 cycles starting at the count `rxStart`, most significant bit first. In the cycle after the final bit cell, `rxValid` is high for one cycle and `rxWord` holds the word.
- R4: The transmit start and the receive start are independent. Each one places its own word, whatever the value of the other.
- R5: A start value greater than or equal to `frameLen` produces no transfer in that direction: `dtxOe` stays low, or `rxValid` stays low.
- R6: With `wideband` high, a second word starts at the start value plus `frameLen`/2 (rounded down), but only if that position is below `frameLen`. The second transmit word comes from `txWord1`. A received second word has `rxSlot` = 1; a first word has `rxSlot` = 0.
- R7: With `relEarly` = 1, `dtxOe` falls at the falling edge inside the last cycle of the word. With `relEarly` = 0, it falls at the rising edge that ends that cycle.
- R8: With `gciMode` high, each bit spans two cycles, so a word spans 32 cycles. Receive samples `drx` at the falling edge of the second cycle of each bit.
- R9: The transmit word is captured at the rising edge that starts it. A change of `txWord0` while the word is on the line does not alter the bits sent.
- R10: Outside a transmit word `dtxOe` is 0 and `dtxData` is 0. While `dtxOe` is low, `dtxData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Highway bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame start mark, sampled on the rising edge |
| frameLen | input | 11 | Bit-clock cycles per frame (32 to 1024) |
| txStart | input | 11 | Count at which the transmit word begins |
| rxStart | input | 11 | Count at which the receive word begins |
| wideband | input | 1 | Enables the second word half a frame later |
| gciMode | input | 1 | Two bit-clock cycles per data bit |
| relEarly | input | 1 | 1: release the enable mid-way through the last cell |
| txWord0 | input | 16 | First transmit sample |
| txWord1 | input | 16 | Second (wideband) transmit sample |
| drx | input | 1 | Serial receive data |
| dtxData | output | 1 | Serial transmit data |
| dtxOe | output | 1 | Output enable for the transmit pad |
| rxWord | output | 16 | Last received sample |
| rxValid | output | 1 | One-cycle strobe: `rxWord` is new |
| rxSlot | output | 1 | 0 for the first word of the frame, 1 for the second |

## Verification
Timing follows from the count: the count holds the value c in the c-th cycle after the cycle in which `fsync` was seen.
- A transmit bit is due in the same cycle as the count that owns it. Transmit data and the enable are therefore compared 3 ns after the rising edge that opens that cycle.
- The early release appears only after the falling edge. The enable is therefore compared a second time 7 ns after the rising edge, in the low half.
- Receive data driven in a cycle is consumed at that cycle's falling edge. `rxValid`, `rxWord` and `rxSlot` are due one cycle after the last bit cell, so they are checked 3 ns into the cycle at count start plus word length.

Frame syncs and configuration changes are issued only while both directions are idle.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  // Strobes from the sequencing control to the shift datapath.
  typedef struct packed {
    logic txLoad;     // capture a transmit word at this edge
    logic txLoadSel;  // 1: the word captured is the second one
    logic txAdvance;  // move to the next transmit bit at this edge
    logic txBusy;     // a transmit word occupies the current cycle
    logic txLast;     // current cycle is the final cell of the transmit word
    logic rxLoad;     // a receive word starts at this edge
    logic rxLoadSel;  // 1: that receive word is the second one
    logic rxSample;   // shift drx in at the coming falling edge
    logic rxLast;     // current cycle is the final cell of the receive word
  } pcmStrobes_t;

endpackage

// File: rtl/pcm_slot_tracker.sv
module pcm_slot_tracker #(
  parameter int CNT_W = 11,
  parameter int WORD_W = 16,
  localparam int POS_W = $clog2(2 * WORD_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] nextCnt,
  input  logic [CNT_W-1:0] frameLen,
  input  logic [CNT_W-1:0] startCnt,
  input  logic             wideband,
  input  logic             gciMode,
  output logic             hit,
  output logic             hitSel,
  output logic             busy,
  output logic             last,
  output logic             phase
);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] lastPos;
  logic [CNT_W:0]   secondStart;
  logic             hitFirst;
  logic             hitSecond;

  // The second word sits half a frame after the first one.
  assign secondStart = {1'b0, startCnt} + {2'b00, frameLen[CNT_W-1:1]};
  assign hitFirst    = (nextCnt == startCnt) && (startCnt < frameLen);
  assign hitSecond   = wideband && ({1'b0, nextCnt} == secondStart)
                       && (secondStart < {1'b0, frameLen});
  assign hit         = hitFirst | hitSecond;
  assign hitSel      = ~hitFirst;

  assign lastPos = gciMode ? POS_W'(2 * WORD_W - 1) : POS_W'(WORD_W - 1);
  assign last    = busy && (pos == lastPos);
  assign phase   = pos[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      pos  <= '0;
    end else if (hit) begin
      busy <= 1'b1;
      pos  <= '0;
    end else if (busy) begin
      if (pos == lastPos) begin
        busy <= 1'b0;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int WORD_W = 16
) (
  input  logic             pclk,
  input  logic             rstN,
  input  logic             fsync,
  input  logic [CNT_W-1:0] frameLen,
  input  logic [CNT_W-1:0] txStart,
  input  logic [CNT_W-1:0] rxStart,
  input  logic             wideband,
  input  logic             gciMode,
  output pcmStrobes_t      strobes,
  output logic [CNT_W-1:0] frameCnt
);

  localparam int NUM_DIR = 2;  // index 0: transmit, 1: receive

  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] dirStart [NUM_DIR];
  logic [NUM_DIR-1:0] hitV, selV, busyV, lastV, phaseV, bitEndV;

  // Count stops at the frame length so a late start never matches.
  always_comb begin
    if (fsync) begin
      nextCnt = '0;
    end else if (frameCnt < frameLen) begin
      nextCnt = frameCnt + 1'b1;
    end else begin
      nextCnt = frameCnt;
    end
  end

  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '1;
    end else begin
      frameCnt <= nextCnt;
    end
  end

  assign dirStart[0] = txStart;
  assign dirStart[1] = rxStart;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    pcm_slot_tracker #(
      .CNT_W (CNT_W),
      .WORD_W(WORD_W)
    ) u_track (
      .clk     (pclk),
      .rstN    (rstN),
      .nextCnt (nextCnt),
      .frameLen(frameLen),
      .startCnt(dirStart[d]),
      .wideband(wideband),
      .gciMode (gciMode),
      .hit     (hitV[d]),
      .hitSel  (selV[d]),
      .busy    (busyV[d]),
      .last    (lastV[d]),
      .phase   (phaseV[d])
    );
    // A bit cell ends every cycle, or every second cycle in double-clock mode.
    assign bitEndV[d] = busyV[d] && (!gciMode || phaseV[d]);
  end

  always_comb begin
    strobes.txLoad    = hitV[0];
    strobes.txLoadSel = selV[0];
    strobes.txAdvance = bitEndV[0] & ~lastV[0];
    strobes.txBusy    = busyV[0];
    strobes.txLast    = lastV[0];
    strobes.rxLoad    = hitV[1];
    strobes.rxLoadSel = selV[1];
    strobes.rxSample  = bitEndV[1];
    strobes.rxLast    = lastV[1];
  end

endmodule

// File: rtl/pcm_port_dp.sv
module pcm_port_dp
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              pclk,
  input  logic              rstN,
  input  pcmStrobes_t       strobes,
  input  logic [WORD_W-1:0] txWord0,
  input  logic [WORD_W-1:0] txWord1,
  input  logic              relEarly,
  input  logic              drx,
  output logic              dtxData,
  output logic              dtxOe,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              rxSlot
);

  logic [WORD_W-1:0] txReg;
  logic [WORD_W-1:0] rxReg;
  logic              posPhase;
  logic              negPhase;
  logic              lowHalf;
  logic              rxSlotQ;

  // Transmit shifter: the word is frozen at the edge that starts it.
  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (strobes.txLoad) begin
      txReg <= strobes.txLoadSel ? txWord1 : txWord0;
    end else if (strobes.txAdvance) begin
      txReg <= {txReg[WORD_W-2:0], 1'b0};
    end
  end

  // Phase pair: differs from a falling edge until the next rising edge.
  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) posPhase <= 1'b0;
    else       posPhase <= negPhase;
  end

  always_ff @(negedge pclk or negedge rstN) begin
    if (!rstN) negPhase <= 1'b0;
    else       negPhase <= ~posPhase;
  end

  assign lowHalf = negPhase ^ posPhase;
  assign dtxOe   = strobes.txBusy & ~(relEarly & strobes.txLast & lowHalf);
  assign dtxData = dtxOe & txReg[WORD_W-1];

  // Receive shifter, clocked on the falling edge.
  always_ff @(negedge pclk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
    end else if (strobes.rxSample) begin
      rxReg <= {rxReg[WORD_W-2:0], drx};
    end
  end

  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) begin
      rxSlotQ <= 1'b0;
      rxValid <= 1'b0;
      rxWord  <= '0;
      rxSlot  <= 1'b0;
    end else begin
      if (strobes.rxLoad) rxSlotQ <= strobes.rxLoadSel;
      rxValid <= strobes.rxLast;
      if (strobes.rxLast) begin
        rxWord <= rxReg;
        rxSlot <= rxSlotQ;
      end
    end
  end

endmodule

// File: rtl/pcm_port.sv
module pcm_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int MAX_SLOTS = 64,
  localparam int CNT_W = $clog2(MAX_SLOTS * WORD_W + 1)
) (
  input  logic              pclk,
  input  logic              rstN,
  input  logic              fsync,
  input  logic [CNT_W-1:0]  frameLen,
  input  logic [CNT_W-1:0]  txStart,
  input  logic [CNT_W-1:0]  rxStart,
  input  logic              wideband,
  input  logic              gciMode,
  input  logic              relEarly,
  input  logic [WORD_W-1:0] txWord0,
  input  logic [WORD_W-1:0] txWord1,
  input  logic              drx,
  output logic              dtxData,
  output logic              dtxOe,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              rxSlot
);

  pcmStrobes_t      strobes;
  logic [CNT_W-1:0] frameCnt;

  pcm_port_ctrl #(
    .CNT_W (CNT_W),
    .WORD_W(WORD_W)
  ) u_ctrl (
    .pclk    (pclk),
    .rstN    (rstN),
    .fsync   (fsync),
    .frameLen(frameLen),
    .txStart (txStart),
    .rxStart (rxStart),
    .wideband(wideband),
    .gciMode (gciMode),
    .strobes (strobes),
    .frameCnt(frameCnt)
  );

  pcm_port_dp #(
    .WORD_W(WORD_W)
  ) u_dp (
    .pclk    (pclk),
    .rstN    (rstN),
    .strobes (strobes),
    .txWord0 (txWord0),
    .txWord1 (txWord1),
    .relEarly(relEarly),
    .drx     (drx),
    .dtxData (dtxData),
    .dtxOe   (dtxOe),
    .rxWord  (rxWord),
    .rxValid (rxValid),
    .rxSlot  (rxSlot)
  );

endmodule

// File: rtl/pcm_port_checker.sv
module pcm_port_checker #(
  parameter int CNT_W = 11
) (
  input logic             pclk,
  input logic             rstN,
  input logic             fsync,
  input logic [CNT_W-1:0] frameLen,
  input logic [CNT_W-1:0] txStart,
  input logic             wideband,
  input logic             dtxOe,
  input logic             rxValid,
  input logic [CNT_W-1:0] frameCnt
);

  p_fsync_zero_r1: assert property (@(posedge pclk) disable iff (!rstN)
    fsync |=> (frameCnt == '0));

  p_count_step_r1: assert property (@(posedge pclk) disable iff (!rstN)
    ($past(!fsync) && ($past(frameCnt) < $past(frameLen)))
      |-> (frameCnt == CNT_W'($past(frameCnt) + 1'b1)));

  p_count_hold_r1: assert property (@(posedge pclk) disable iff (!rstN)
    ($past(!fsync) && ($past(frameCnt) >= $past(frameLen)))
      |-> (frameCnt == $past(frameCnt)));

  p_valid_pulse_r3: assert property (@(posedge pclk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_tx_disabled_r5: assert property (@(posedge pclk) disable iff (!rstN)
    (!wideband && (txStart >= frameLen)) |=> !$rose(dtxOe));

endmodule

bind pcm_port pcm_port_checker #(.CNT_W(CNT_W)) u_chk (
  .pclk    (pclk),
  .rstN    (rstN),
  .fsync   (fsync),
  .frameLen(frameLen),
  .txStart (txStart),
  .wideband(wideband),
  .dtxOe   (dtxOe),
  .rxValid (rxValid),
  .frameCnt(frameCnt)
);

// File: tb/pcm_port_bench.sv
module pcm_port_bench;

  localparam int W  = 16;
  localparam int CW = 11;

  logic          pclk = 1'b0;
  logic          rstN = 1'b0;
  logic          fsync = 1'b0;
  logic [CW-1:0] frameLen = CW'(32);
  logic [CW-1:0] txStart = '0;
  logic [CW-1:0] rxStart = '0;
  logic          wideband = 1'b0;
  logic          gciMode = 1'b0;
  logic          relEarly = 1'b0;
  logic [W-1:0]  txWord0 = '0;
  logic [W-1:0]  txWord1 = '0;
  logic          drx = 1'b0;
  logic          dtxData, dtxOe, rxValid, rxSlot;
  logic [W-1:0]  rxWord;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 pclk = ~pclk;

  pcm_port u_pcm_port (
    .pclk(pclk), .rstN(rstN), .fsync(fsync), .frameLen(frameLen),
    .txStart(txStart), .rxStart(rxStart), .wideband(wideband),
    .gciMode(gciMode), .relEarly(relEarly), .txWord0(txWord0),
    .txWord1(txWord1), .drx(drx), .dtxData(dtxData), .dtxOe(dtxOe),
    .rxWord(rxWord), .rxValid(rxValid), .rxSlot(rxSlot)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Bit index of count c inside a word at base, or -1 when outside it.
  function automatic int bitAt(int c, int base, bit en, int len, bit g);
    if (!en || c < base || c >= base + len) return -1;
    return (c - base) >> g;
  endfunction

  task automatic runConfig(int fl, int ts, int rs, bit wb, bit g, bit rel,
                           int nFrames, int idle, string cfgTag);
    int len = g ? 32 : 16;
    int half = fl / 2;
    int tb[2];
    int rb[2];
    bit ten[2];
    bit ren[2];
    logic [W-1:0] expTx[2];
    logic [W-1:0] rxPat[2];
    tb[0] = ts;         ten[0] = (ts < fl);
    tb[1] = ts + half;  ten[1] = wb && (tb[1] < fl);
    rb[0] = rs;         ren[0] = (rs < fl);
    rb[1] = rs + half;  ren[1] = wb && (rb[1] < fl);
    txWord1 = W'($urandom);

    // Configuration cycle, which also carries the frame sync.
    @(posedge pclk); #1;
    frameLen = CW'(fl); txStart = CW'(ts); rxStart = CW'(rs);
    wideband = wb; gciMode = g; relEarly = rel; fsync = 1'b1; drx = 1'($urandom);
    #2;
    chk({"R10/", cfgTag}, "dtxOe before frame", dtxOe, 0);
    chk({"R3/", cfgTag}, "rxValid before frame", rxValid, 0);
    #4;
    chk({"R10/", cfgTag}, "dtxOe low half before frame", dtxOe, 0);

    for (int f = 0; f < nFrames; f++) begin
      rxPat[0] = W'($urandom);
      rxPat[1] = W'($urandom);
      expTx[0] = txWord0;
      expTx[1] = txWord1;
      for (int c = 0; c < fl; c++) begin
        bit eo, ed, endLsb, ev, es;
        logic [W-1:0] ew;
        string txTag;
        @(posedge pclk); #1;
        fsync = (c == fl - 1) && (f < nFrames - 1);
        drx = 1'($urandom);
        for (int s = 0; s < 2; s++) begin
          int b = bitAt(c, rb[s], ren[s], len, g);
          if (b >= 0) drx = rxPat[s][W-1-b];
        end
        if (c == ts + 1) txWord0 = W'($urandom);  // R9: change mid-word
        #2;
        eo = 0; ed = 0; endLsb = 0; txTag = "R10";
        for (int s = 0; s < 2; s++) begin
          int b = bitAt(c, tb[s], ten[s], len, g);
          if (b >= 0) begin
            eo = 1;
            ed = expTx[s][W-1-b];
            endLsb = (c == tb[s] + len - 1);
            txTag = (s == 1) ? "R6" : (g ? "R8" : "R2,R9");
          end
        end
        chk({txTag, "/", cfgTag}, "dtxOe", dtxOe, eo);
        chk({txTag, "/", cfgTag}, "dtxData", dtxData, ed);
        ev = 0; es = 0; ew = '0;
        for (int s = 0; s < 2; s++) begin
          if (ren[s] && c == rb[s] + len) begin
            ev = 1; ew = rxPat[s]; es = s[0];
          end
        end
        chk({"R3/", cfgTag}, "rxValid", rxValid, ev);
        if (ev) begin
          chk({(g ? "R8" : "R3"), "/", cfgTag}, "rxWord", rxWord, ew);
          chk({"R6/", cfgTag}, "rxSlot", rxSlot, es);
        end
        #4;
        chk({(eo ? "R7" : "R10"), "/", cfgTag}, "dtxOe low half",
            dtxOe, eo && !(rel && endLsb));
      end
    end

    // Without a frame sync the count stops: no word may start again.
    for (int i = 0; i < idle; i++) begin
      @(posedge pclk); #1;
      fsync = 1'b0; drx = 1'($urandom);
      #2;
      chk({"R1/", cfgTag}, "dtxOe with parked count", dtxOe, 0);
      chk({"R1/", cfgTag}, "rxValid with parked count", rxValid, 0);
    end
  endtask

  initial begin
    repeat (195000) @(posedge pclk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge pclk);
    #1 rstN = 1'b1;
    #2;
    chk("R1", "rxWord after reset", rxWord, 0);
    chk("R1", "rxValid after reset", rxValid, 0);
    chk("R1", "dtxOe after reset", dtxOe, 0);
    // No frame sync yet: nothing may move even with start values of 0.
    for (int i = 0; i < 40; i++) begin
      @(posedge pclk); #1 drx = 1'($urandom);
      #2;
      chk("R1", "dtxOe before first fsync", dtxOe, 0);
      chk("R1", "rxValid before first fsync", rxValid, 0);
    end

    // Directed corner cases.
    runConfig(32, 0, 10, 0, 0, 0, 3, 0, "R4 basic");
    runConfig(64, 20, 3, 0, 0, 1, 3, 0, "R4 early release");
    runConfig(64, 64, 100, 0, 0, 0, 2, 0, "R5 both off");
    runConfig(64, 10, 64, 0, 0, 1, 2, 0, "R5 rx off");
    runConfig(128, 5, 30, 1, 0, 0, 2, 0, "R6 wideband");
    runConfig(128, 47, 0, 1, 0, 1, 2, 0, "R6 back to back");
    runConfig(64, 40, 35, 1, 0, 0, 2, 0, "R6 second beyond frame");
    runConfig(64, 2, 20, 0, 1, 1, 2, 0, "R8 double clock");
    runConfig(256, 10, 60, 1, 1, 0, 2, 0, "R8 double clock wideband");
    runConfig(32, 2, 4, 0, 0, 0, 1, 40, "R1 hold");

    // Random configurations.
    for (int k = 0; k < 16; k++) begin
      int fl, len, ts, rs;
      bit g, wb, rel;
      fl  = 32 << ($urandom % 5);
      g   = 1'($urandom);
      rel = 1'($urandom);
      len = g ? 32 : 16;
      wb  = (fl >= (g ? 128 : 64)) ? 1'($urandom) : 1'b0;
      if (wb) begin
        ts = $urandom % (fl / 2 - len);
        rs = $urandom % (fl / 2 - len);
      end else begin
        ts = $urandom % (fl - len);
        rs = $urandom % (fl - len);
      end
      if ($urandom % 8 == 0) ts = fl + $urandom % 8;
      if ($urandom % 8 == 0) rs = fl + $urandom % 8;
      runConfig(fl, ts, rs, wb, g, rel, 2, 0, "R4 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule